// File: doc/BRIEF.md
# DAC Command Register Controller

This block is the register-side controller for a digital-to-analog converter. Software uses a plain parallel port to write and read four registers: a command word, the input data code, an offset correction word and a gain correction word. The command word chooses the resolution and the settling policy, clears the output code, zeroes the correction words, controls the sample-and-hold reference link and starts a self-calibration.

A self-calibration runs for a fixed number of clock cycles. For that whole time every register write is dropped and `busy` stays high. At the end, the measurements from a fixed-value stub are loaded into the correction registers and the mode field falls back to normal. For each accepted data write, the block also decides whether the converter may use fast settling. That decision depends on the settling policy in the command word and on the size of the step from the previous output code.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: Writing the command word (address 0) with mode field bits [1:0] = 01 and sample-and-hold bit [2] = 1 makes `busy` rise at the clock edge after the write. If mode is 01 while bit [2] is 0, no calibration starts and writes stay accepted.
- R2: Once calibration has started, `busy` stays high for exactly CAL_CYCLES clock cycles.
- R3: From the write that requests calibration until `busy` falls, every register write is ignored. This covers the command word, data (address 1), offset (address 2) and gain (address 3).
- R4: While the request is pending and while calibration runs, the mode field reads back 01. When calibration ends it reads 00, and all other command bits keep their values.
- R5: When calibration ends, the offset register holds the stub offset with its most significant bit inverted, which converts two's complement to offset binary. The gain register holds the stub gain unchanged.
- R6: While clear bit [5] is set, the data register is forced to zero at every clock edge and data writes are ignored.
- R7: While correction-reset bit [6] is set, the offset and gain registers are forced to zero, and this overrides a calibration result.
- R8: Resolution bit [4] = 1 sends all 20 data bits to `dac_code`. When it is 0, the low 4 bits of `dac_code` read zero. The data register always reads back unmasked.
- R9: If adaptive bit [7] and disable bit [8] are both 0, an accepted data write sets `fast_settle` to 1 when the absolute difference between the new and the previous effective code is at least SMALL_STEP. Otherwise it sets `fast_settle` to 0.
- R10: With bit [7] = 1 an accepted data write sets `fast_settle` to 1. With bit [8] = 1 it sets it to 0, whatever bit [7] is.
- R11: `out_isolate` is high only while calibrating with calibration-pin bit [3] = 0. `hold_ref` follows bit [2].
- R12: When `rst_n` is low, all registers and outputs go to zero. Outside calibration, each of the four registers reads back what was written to it, zero-extended to REG_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register select for both write and read |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Read data for `addr`, combinational |
| dac_code | output | DATA_W | Effective code sent to the converter |
| fast_settle | output | 1 | Fast-settling enable for the latest accepted code |
| busy | output | 1 | Self-calibration in progress |
| out_isolate | output | 1 | Output disconnected during calibration |
| hold_ref | output | 1 | Sample-and-hold capacitor linked to the reference |

## Verification
The assertions assume that `addr` and `wr_data` are stable whenever `wr_en` is sampled. They also assume that the correction-reset and clear bits are only changed outside calibration, so the register freeze seen during `busy` is due to the lock alone. The stimulus drives every write at the falling edge, holds it for one full cycle and then drops `wr_en`. During calibration it makes writes only to the command and data registers, which shows the lock without racing the final loading edge.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

   typedef struct packed {
      logic       disf;    // [8] disable fast settling
      logic       adpt;    // [7] always fast settling
      logic       crst;    // [6] zero correction words
      logic       clr;     // [5] zero data code
      logic       res;     // [4] 1 = 20-bit, 0 = 16-bit
      logic       calpin;  // [3] keep output connected during calibration
      logic       sh;      // [2] sample-and-hold reference link
      logic [1:0] mode;    // [1:0] operation mode
   } cmd_t;

   localparam int CMD_W = $bits(cmd_t);

   localparam logic [1:0] MODE_NORMAL  = 2'b00;
   localparam logic [1:0] MODE_SELFCAL = 2'b01;

   localparam logic [1:0] A_CMD  = 2'd0;
   localparam logic [1:0] A_DATA = 2'd1;
   localparam logic [1:0] A_OFS  = 2'd2;
   localparam logic [1:0] A_GAIN = 2'd3;

endpackage

// File: rtl/dac_code_mask.sv
module dac_code_mask #(
   parameter int DATA_W   = 20,
   parameter int SIG_BITS = 16
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic              full_res,
   output logic [DATA_W-1:0] code_out
);
   localparam int LOW_BITS = DATA_W - SIG_BITS;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i < LOW_BITS) begin : g_low
         assign code_out[i] = data_in[i] & full_res;
      end else begin : g_high
         assign code_out[i] = data_in[i];
      end
   end
endmodule

// File: rtl/dac_settle_ctl.sv
module dac_settle_ctl #(
   parameter int DATA_W     = 20,
   parameter int SMALL_STEP = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] new_code,
   input  logic [DATA_W-1:0] prev_code,
   input  logic              force_fast,
   input  logic              kill_fast,
   output logic              fast
);
   localparam logic [DATA_W-1:0] THR = DATA_W'(SMALL_STEP);

   logic [DATA_W-1:0] step_mag;
   logic              small_step;

   always_comb begin
      if (new_code >= prev_code) step_mag = new_code - prev_code;
      else                       step_mag = prev_code - new_code;
      small_step = step_mag < THR;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    fast <= 1'b0;
      else if (load) fast <= !kill_fast && (force_fast || !small_step);
   end
endmodule

// File: rtl/dac_cal_seq.sv
module dac_cal_seq #(
   parameter int              CAL_CYCLES = 16,
   parameter int              CORR_W     = 24,
   parameter logic [CORR_W-1:0] OFS_RAW  = '0,
   parameter logic [CORR_W-1:0] GAIN_RAW = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              active,
   output logic              done,
   output logic [CORR_W-1:0] ofs_meas,
   output logic [CORR_W-1:0] gain_meas
);
   localparam int                CNT_W    = $clog2(CAL_CYCLES);
   localparam logic [CNT_W-1:0]  LAST     = CNT_W'(CAL_CYCLES - 1);
   localparam logic [CORR_W-1:0] SIGN_BIT = {1'b1, {(CORR_W-1){1'b0}}};

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (start && !active) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (active) begin
         if (cnt == LAST) active <= 1'b0;
         else             cnt    <= cnt + 1'b1;
      end
   end

   assign done      = active && (cnt == LAST);
   // stub measurement: offset converted to offset binary, gain as measured
   assign ofs_meas  = OFS_RAW ^ SIGN_BIT;
   assign gain_meas = GAIN_RAW;
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
   import dac_cmd_pkg::*;
#(
   parameter int               DATA_W     = 20,
   parameter int               REG_W      = 24,
   parameter int               CAL_CYCLES = 16,
   parameter int               SMALL_STEP = 64,
   parameter logic [REG_W-1:0] OFS_RAW    = 24'hFFFFF0,
   parameter logic [REG_W-1:0] GAIN_RAW   = 24'h012345
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   output logic [DATA_W-1:0] dac_code,
   output logic              fast_settle,
   output logic              busy,
   output logic              out_isolate,
   output logic              hold_ref
);
   if (DATA_W <= 16 || REG_W < DATA_W || REG_W < CMD_W) begin : g_bad_width
      $error("dac_cmd_ctrl: DATA_W must exceed 16 and fit in REG_W");
   end
   if (CAL_CYCLES < 2) begin : g_bad_cal
      $error("dac_cmd_ctrl: CAL_CYCLES must be at least 2");
   end

   cmd_t              cmd_q;
   logic [DATA_W-1:0] data_q;
   logic [REG_W-1:0]  ofs_q, gain_q;
   logic              cal_active, cal_done;
   logic [REG_W-1:0]  ofs_meas, gain_meas;
   logic              start_pend, wr_lock, wr_ok, data_we;
   logic [DATA_W-1:0] next_code;

   assign start_pend = (cmd_q.mode == MODE_SELFCAL) && cmd_q.sh && !cal_active;
   assign wr_lock    = cal_active || start_pend;
   assign wr_ok      = wr_en && !wr_lock;
   assign data_we    = wr_ok && (addr == A_DATA) && !cmd_q.clr;

   dac_cal_seq #(
      .CAL_CYCLES(CAL_CYCLES), .CORR_W(REG_W),
      .OFS_RAW(OFS_RAW), .GAIN_RAW(GAIN_RAW)
   ) u_cal (
      .clk(clk), .rst_n(rst_n), .start(start_pend),
      .active(cal_active), .done(cal_done),
      .ofs_meas(ofs_meas), .gain_meas(gain_meas)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cmd_q      <= '0;
      else if (wr_ok && addr == A_CMD)  cmd_q      <= cmd_t'(wr_data[CMD_W-1:0]);
      else if (cal_done)                cmd_q.mode <= MODE_NORMAL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         data_q <= '0;
      else if (cmd_q.clr) data_q <= '0;
      else if (data_we)   data_q <= wr_data[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q  <= '0;
         gain_q <= '0;
      end else if (cmd_q.crst) begin
         ofs_q  <= '0;
         gain_q <= '0;
      end else if (cal_done) begin
         ofs_q  <= ofs_meas;
         gain_q <= gain_meas;
      end else if (wr_ok) begin
         if (addr == A_OFS)  ofs_q  <= wr_data;
         if (addr == A_GAIN) gain_q <= wr_data;
      end
   end

   dac_code_mask #(.DATA_W(DATA_W)) u_mask_out (
      .data_in(data_q), .full_res(cmd_q.res), .code_out(dac_code)
   );

   dac_code_mask #(.DATA_W(DATA_W)) u_mask_new (
      .data_in(wr_data[DATA_W-1:0]), .full_res(cmd_q.res), .code_out(next_code)
   );

   dac_settle_ctl #(.DATA_W(DATA_W), .SMALL_STEP(SMALL_STEP)) u_settle (
      .clk(clk), .rst_n(rst_n), .load(data_we),
      .new_code(next_code), .prev_code(dac_code),
      .force_fast(cmd_q.adpt), .kill_fast(cmd_q.disf), .fast(fast_settle)
   );

   always_comb begin
      case (addr)
         A_CMD:   rd_data = REG_W'(cmd_q);
         A_DATA:  rd_data = REG_W'(data_q);
         A_OFS:   rd_data = ofs_q;
         default: rd_data = gain_q;
      endcase
   end

   assign busy        = cal_active;
   assign out_isolate = cal_active && !cmd_q.calpin;
   assign hold_ref    = cmd_q.sh;
endmodule

// File: rtl/dac_cmd_chk.sv
module dac_cmd_chk
   import dac_cmd_pkg::*;
#(
   parameter int DATA_W = 20,
   parameter int REG_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              busy,
   input logic              out_isolate,
   input logic              fast_settle,
   input cmd_t              cmd_q,
   input logic [DATA_W-1:0] data_q,
   input logic [REG_W-1:0]  ofs_q,
   input logic [REG_W-1:0]  gain_q,
   input logic              wr_lock,
   input logic              data_we
);
   // R1
   cal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_q.mode == MODE_SELFCAL && cmd_q.sh));

   // R3
   write_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lock && wr_en) |=> $stable(data_q));

   // R4
   mode_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cmd_q.mode == MODE_SELFCAL));

   // R4
   mode_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (cmd_q.mode == MODE_NORMAL));

   // R6
   clear_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_q.clr |=> (data_q == '0));

   // R7
   corr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_q.crst |=> (ofs_q == '0 && gain_q == '0));

   // R10
   settle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && cmd_q.disf) |=> !fast_settle);

   // R10
   settle_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && cmd_q.adpt && !cmd_q.disf) |=> fast_settle);

   // R11
   isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_isolate |-> (busy && !cmd_q.calpin));
endmodule

bind dac_cmd_ctrl dac_cmd_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
   .out_isolate(out_isolate), .fast_settle(fast_settle),
   .cmd_q(cmd_q), .data_q(data_q), .ofs_q(ofs_q), .gain_q(gain_q),
   .wr_lock(wr_lock), .data_we(data_we)
);

// File: tb/tb_dac_cmd_ctrl.sv
module tb_dac_cmd_ctrl;
   localparam int          DW    = 20;
   localparam int          RW    = 24;
   localparam int          CAL   = 8;
   localparam int          STEP  = 16;
   localparam logic [23:0] OFS_R = 24'hFFFFF0;
   localparam logic [23:0] GN_R  = 24'h012345;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [RW-1:0] wr_data = '0;
   logic [RW-1:0] rd_data;
   logic [DW-1:0] dac_code;
   logic          fast_settle, busy, out_isolate, hold_ref;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   dac_cmd_ctrl #(
      .DATA_W(DW), .REG_W(RW), .CAL_CYCLES(CAL), .SMALL_STEP(STEP),
      .OFS_RAW(OFS_R), .GAIN_RAW(GN_R)
   ) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .dac_code(dac_code), .fast_settle(fast_settle),
      .busy(busy), .out_isolate(out_isolate), .hold_ref(hold_ref)
   );

   always #10 clk = ~clk;

   // sel: 0..3 register read, 4 dac_code, 5 fast_settle, 6 busy, 7 out_isolate, 8 hold_ref
   typedef struct {
      int          sel;
      logic [23:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];

   task automatic check(input logic [23:0] act, input logic [23:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops expected items and compares with the live outputs
   initial begin
      forever begin
         item_t it;
         logic [23:0] act;
         wait (sb_q.size() > 0);
         #1;
         it = sb_q.pop_front();
         case (it.sel)
            0, 1, 2, 3: act = rd_data;
            4:          act = 24'(dac_code);
            5:          act = 24'(fast_settle);
            6:          act = 24'(busy);
            7:          act = 24'(out_isolate);
            default:    act = 24'(hold_ref);
         endcase
         check(act, it.exp, it.tag);
      end
   end

   // driver side
   task automatic expect_val(input int sel, input logic [23:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      wr_en = 1'b0;
      if (sel < 4) addr = 2'(sel);
      it.sel = sel; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
      #2;
   endtask

   task automatic wr(input logic [1:0] a, input logic [23:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 100 && busy; i++) @(negedge clk);
   endtask

   function automatic logic [23:0] eff(input logic [19:0] v, input bit full);
      return full ? 24'(v) : 24'(v & 20'hFFFF0);
   endfunction

   initial begin
      #(20 * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      expect_val(0, 24'h0, "R12 cmd reset");
      expect_val(1, 24'h0, "R12 data reset");
      expect_val(2, 24'h0, "R12 ofs reset");
      expect_val(3, 24'h0, "R12 gain reset");
      expect_val(4, 24'h0, "R12 dac_code reset");
      expect_val(6, 24'h0, "R12 busy reset");

      // R8 20-bit, R9 adaptive policy
      wr(2'd0, 24'h010);
      wr(2'd1, 24'h12345);
      expect_val(4, eff(20'h12345, 1), "R8 20-bit code");
      expect_val(5, 24'h1, "R9 large step fast");
      wr(2'd1, 24'h12348);
      expect_val(5, 24'h0, "R9 small step slow");

      // R10 forced fast, then disabled over forced
      wr(2'd0, 24'h090);
      wr(2'd1, 24'h12349);
      expect_val(5, 24'h1, "R10 forced fast on small step");
      wr(2'd0, 24'h190);
      wr(2'd1, 24'h50000);
      expect_val(5, 24'h0, "R10 disable overrides");

      // R8 16-bit mask, R9 step on effective code
      wr(2'd0, 24'h000);
      wr(2'd1, 24'h12345);
      expect_val(4, eff(20'h12345, 0), "R8 16-bit mask");
      expect_val(5, 24'h1, "R9 16-bit large step");
      wr(2'd1, 24'h1234F);
      expect_val(5, 24'h0, "R9 16-bit hidden step");
      expect_val(1, 24'h1234F, "R8 raw readback");

      // R6 clear
      wr(2'd0, 24'h030);
      expect_val(4, 24'h0, "R6 clear zeroes code");
      wr(2'd1, 24'hABCDE);
      expect_val(1, 24'h0, "R6 write ignored under clear");
      wr(2'd0, 24'h010);
      expect_val(1, 24'h0, "R6 data stays zero");

      // R11 sample-and-hold follows bit 2
      wr(2'd1, 24'h11111);
      wr(2'd0, 24'h014);
      expect_val(8, 24'h1, "R11 hold_ref set");

      // R1 mode 01 without sh: no calibration
      wr(2'd0, 24'h011);
      expect_val(6, 24'h0, "R1 no start without sh");
      expect_val(8, 24'h0, "R11 hold_ref clear");
      wr(2'd1, 24'h22222);
      expect_val(1, 24'h22222, "R1 writes still accepted");
      wr(2'd1, 24'h11111);

      // R1/R3/R4/R5/R11 calibration with output isolated
      wr(2'd0, 24'h015);
      expect_val(6, 24'h1, "R1 busy after start");
      expect_val(0, 24'h015, "R4 mode reads 01");
      expect_val(7, 24'h1, "R11 isolated during cal");
      wr(2'd1, 24'h77777);
      wr(2'd0, 24'h000);
      wait_idle();
      expect_val(1, 24'h11111, "R3 data write locked");
      expect_val(0, 24'h014, "R4 mode back to 00");
      expect_val(2, OFS_R ^ 24'h800000, "R5 offset binary");
      expect_val(3, GN_R, "R5 gain unadjusted");

      // R2 exact length, connected output
      wr(2'd0, 24'h01D);
      n = 0;
      for (int i = 0; i < 3 * CAL; i++) begin
         @(negedge clk);
         if (busy) n++;
      end
      check(24'(n), 24'(CAL), "R2 busy length");

      wr(2'd0, 24'h01D);
      expect_val(7, 24'h0, "R11 connected during cal");
      wait_idle();

      // R7 correction reset
      wr(2'd0, 24'h054);
      expect_val(2, 24'h0, "R7 offset zeroed");
      expect_val(3, 24'h0, "R7 gain zeroed");
      wr(2'd0, 24'h014);
      wr(2'd2, 24'h000ABC);
      expect_val(2, 24'h000ABC, "R12 offset write readback");
      wr(2'd3, 24'h00F00D);
      expect_val(3, 24'h00F00D, "R12 gain write readback");

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule